// File: doc/BRIEF.md
# Branch Target Buffer

This block is a direct-mapped table of branch targets that the fetch stage reads with the current fetch address. When the address matches a stored entry, the block returns the predicted next address in the same cycle, so fetch can be steered with no bubble. A miss means fetch continues sequentially. Each branch is presented again at resolve time with its real direction and destination. The block then keeps the table in line with what the branch did and classifies the event with a fixed stall cost.

Each of the 2^IDX_W entries holds a valid flag, a tag and a target. The address is split into three fields. Bits [OFS_W-1:0] are ignored. Bits [OFS_W+IDX_W-1:OFS_W] select the entry. The remaining upper bits form the tag. Resolve updates take effect on the clock edge. A lookup in the same cycle as an update to the same entry returns the old contents.

The resolve port is a valid/ready stream. `rs_ready` is held high, so every beat with `rs_valid` high is accepted in that cycle, and the port never applies back-pressure. The penalty report is a valid-only stream with no ready. It produces one beat per accepted resolve, and the consumer must take every beat.

Top module: `btb_top`

## Requirements
- R1: While reset is low, and after it is released, every entry is invalid, so `lk_hit` is 0 and `lk_target` is 0 for any address.
- R2: `lk_hit` is 1 exactly when the entry selected by the index field of `lk_pc` is valid and its tag equals the upper field of `lk_pc`; `lk_target` is then the stored target, and 0 on a miss; both respond combinationally.
- R3: A taken branch that misses installs (tag, target) at its index, reports outcome 1 (misfetch) and penalty 1.
- R4: A taken branch that hits with the stored target equal to its real target reports outcome 0 (correct) and penalty 0 and leaves the entry unchanged.
- R5: A taken branch that hits with a different real target reports outcome 2 (mispredict) and penalty 2 and overwrites the stored target.
- R6: A not-taken branch that hits reports outcome 2 (mispredict) and penalty 2 and invalidates the entry.
- R7: A not-taken branch that misses reports outcome 0 and penalty 0 and changes no entry; an entry of a different tag at the same index stays.
- R8: A taken miss whose index holds a valid entry of another tag replaces that entry, so the old branch misses afterwards.
- R9: `rs_ready` is always 1; `pen_valid` is 1 in exactly the cycle after each cycle with `rs_valid` high, and when `pen_valid` is 0, `pen_outcome` and `pen_cycles` are 0.
- R10: A lookup in the same cycle as a resolve to the same entry sees the contents from before that resolve.
- R11: Address bits [OFS_W-1:0] take no part in the index or the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | PC_W | Predicted next address on a hit, else 0 |
| rs_valid | input | 1 | Resolve beat present |
| rs_ready | output | 1 | Resolve beat accepted (always 1) |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Branch was taken |
| rs_target | input | PC_W | Real destination of a taken branch |
| pen_valid | output | 1 | Penalty report present |
| pen_outcome | output | 2 | 0 correct, 1 misfetch, 2 mispredict |
| pen_cycles | output | PEN_W | Stall cycles for the reported branch |

## Verification
Directed sequences walk one address through all five resolve cases: install, confirm, retarget, invalidate, and not-taken miss. They then force two tags to collide on one index, which separates replacement from in-place correction. Lookups are placed in the same cycle as the writes they could see, and again with the ignored low address bits varied. This distinguishes old-contents lookup from forwarding and shows that the offset field is dropped. A long random run draws addresses from two tags over all indices, with random directions and targets. It produces frequent hits, aliasing and retargets, and each lookup and penalty is compared with a bench model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    OUT_CLEAN    = 2'd0,
    OUT_MISFETCH = 2'd1,
    OUT_MISPRED  = 2'd2
  } outcome_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_ALLOC    = 2'd1,
    CMD_RETARGET = 2'd2,
    CMD_DROP     = 2'd3
  } cmd_e;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][PC_W-1:0]  rd_pc,
  output logic [NRD-1:0]            rd_hit,
  output logic [NRD-1:0][PC_W-1:0]  rd_tgt,
  input  cmd_e                      wr_cmd,
  input  logic [PC_W-1:0]           wr_pc,
  input  logic [PC_W-1:0]           wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  assign wr_idx = wr_pc[OFS_W +: IDX_W];
  assign wr_tag = wr_pc[PC_W-1 -: TAG_W];

  // valid flags: the only state that reset touches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      case (wr_cmd)
        CMD_ALLOC, CMD_RETARGET: vld_q[wr_idx] <= 1'b1;
        CMD_DROP:                vld_q[wr_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  // tag and target payload
  always_ff @(posedge clk) begin
    if (wr_cmd == CMD_ALLOC) tag_q[wr_idx] <= wr_tag;
    if (wr_cmd == CMD_ALLOC || wr_cmd == CMD_RETARGET) tgt_q[wr_idx] <= wr_tgt;
  end

  // combinational read ports, no bypass of the pending write
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    logic             r_hit;
    assign r_idx     = rd_pc[p][OFS_W +: IDX_W];
    assign r_tag     = rd_pc[p][PC_W-1 -: TAG_W];
    assign r_hit     = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
    assign rd_hit[p] = r_hit;
    assign rd_tgt[p] = r_hit ? tgt_q[r_idx] : '0;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |-> (vld_q == '0)); // R1
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd == CMD_DROP) |=> !vld_q[$past(wr_idx)]); // R6
  AST_ALLOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd == CMD_ALLOC) |=> vld_q[$past(wr_idx)]); // R3
endmodule

// File: rtl/btb_judge.sv
module btb_judge
  import btb_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int PEN_W        = 2,
  parameter int PEN_MISFETCH = 1,
  parameter int PEN_MISPRED  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs_valid,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  input  logic             ent_hit,
  input  logic [PC_W-1:0]  ent_tgt,
  output cmd_e             cmd,
  output outcome_e         outcome,
  output logic [PEN_W-1:0] cycles
);
  always_comb begin
    cmd     = CMD_NONE;
    outcome = OUT_CLEAN;
    if (ent_hit) begin
      if (!rs_taken) begin
        cmd     = CMD_DROP;
        outcome = OUT_MISPRED;
      end else if (ent_tgt != rs_target) begin
        cmd     = CMD_RETARGET;
        outcome = OUT_MISPRED;
      end
    end else if (rs_taken) begin
      cmd     = CMD_ALLOC;
      outcome = OUT_MISFETCH;
    end
    if (!rs_valid) begin
      cmd     = CMD_NONE;
      outcome = OUT_CLEAN;
    end
  end

  always_comb begin
    case (outcome)
      OUT_MISFETCH: cycles = PEN_W'(PEN_MISFETCH);
      OUT_MISPRED:  cycles = PEN_W'(PEN_MISPRED);
      default:      cycles = '0;
    endcase
  end

  AST_ALLOC_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ALLOC) |-> (!ent_hit && rs_taken)); // R3
  AST_NOTTAKEN_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && !ent_hit) |-> (cmd == CMD_NONE)); // R7
endmodule

// File: rtl/btb_report.sv
module btb_report
  import btb_pkg::*;
#(
  parameter int PEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  outcome_e         in_outcome,
  input  logic [PEN_W-1:0] in_cycles,
  output logic             pen_valid,
  output logic [1:0]       pen_outcome,
  output logic [PEN_W-1:0] pen_cycles
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_valid   <= 1'b0;
      pen_outcome <= '0;
      pen_cycles  <= '0;
    end else begin
      pen_valid   <= in_valid;
      pen_outcome <= in_valid ? in_outcome : OUT_CLEAN;
      pen_cycles  <= in_valid ? in_cycles : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_valid |-> (pen_outcome == 2'd0 && pen_cycles == '0)); // R9
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int IDX_W        = 4,
  parameter int OFS_W        = 2,
  parameter int PEN_W        = 2,
  parameter int PEN_MISFETCH = 1,
  parameter int PEN_MISPRED  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic             rs_valid,
  output logic             rs_ready,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  output logic             pen_valid,
  output logic [1:0]       pen_outcome,
  output logic [PEN_W-1:0] pen_cycles
);
  localparam int NRD = 2;

  logic [NRD-1:0][PC_W-1:0] rd_pc;
  logic [NRD-1:0]           rd_hit;
  logic [NRD-1:0][PC_W-1:0] rd_tgt;
  cmd_e                     cmd;
  outcome_e                 outcome;
  logic [PEN_W-1:0]         cycles;
  logic                     acc;

  assign rs_ready = 1'b1;
  assign acc      = rs_valid && rs_ready;
  assign rd_pc    = {rs_pc, lk_pc};
  assign lk_hit    = rd_hit[0];
  assign lk_target = rd_tgt[0];

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_pc(rd_pc), .rd_hit(rd_hit), .rd_tgt(rd_tgt),
    .wr_cmd(cmd), .wr_pc(rs_pc), .wr_tgt(rs_target)
  );

  btb_judge #(.PC_W(PC_W), .PEN_W(PEN_W), .PEN_MISFETCH(PEN_MISFETCH),
              .PEN_MISPRED(PEN_MISPRED)) u_judge (
    .clk(clk), .rst_n(rst_n), .rs_valid(acc), .rs_taken(rs_taken),
    .rs_target(rs_target), .ent_hit(rd_hit[1]), .ent_tgt(rd_tgt[1]),
    .cmd(cmd), .outcome(outcome), .cycles(cycles)
  );

  btb_report #(.PEN_W(PEN_W)) u_report (
    .clk(clk), .rst_n(rst_n), .in_valid(acc), .in_outcome(outcome),
    .in_cycles(cycles), .pen_valid(pen_valid), .pen_outcome(pen_outcome),
    .pen_cycles(pen_cycles)
  );

  AST_TAKEN_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=>
      (lk_pc != $past(rs_pc) || (lk_hit && lk_target == $past(rs_target)))); // R5
  AST_NOTTAKEN_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken) |=> (lk_pc != $past(rs_pc) || !lk_hit)); // R6
  AST_PEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> pen_valid); // R9
  AST_PEN_ONLY_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> !pen_valid); // R9
  AST_CLEAN_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_valid && pen_outcome == 2'd0) |-> (pen_cycles == '0)); // R4
  AST_MISS_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == '0)); // R2
endmodule

// File: tb/sim_btb_top.sv
module sim_btb_top;
  localparam int PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int OFS_W  = 2;
  localparam int PEN_W  = 2;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_W  = PC_W - IDX_W - OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0, rs_target = '0;
  logic rs_valid = 1'b0, rs_taken = 1'b0;
  logic lk_hit, rs_ready, pen_valid;
  logic [PC_W-1:0] lk_target;
  logic [1:0] pen_outcome;
  logic [PEN_W-1:0] pen_cycles;

  int checks = 0;
  int errors = 0;

  btb_top #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .PEN_W(PEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_target(rs_target), .pen_valid(pen_valid), .pen_outcome(pen_outcome),
    .pen_cycles(pen_cycles)
  );

  always #(PERIOD/2) clk = ~clk;

  // bench model of the table
  logic             m_vld [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0]  m_tgt [DEPTH];

  logic       pend = 1'b0;
  logic [1:0] p_out = '0;
  logic [1:0] p_cyc = '0;
  string      p_req = "R9";

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[OFS_W +: IDX_W]);
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [PC_W-1:0] pc);
    return pc[PC_W-1 -: TAG_W];
  endfunction
  function automatic logic m_hit(logic [PC_W-1:0] pc);
    return m_vld[idx_of(pc)] && m_tag[idx_of(pc)] == tag_of(pc);
  endfunction
  function automatic logic [PC_W-1:0] m_target(logic [PC_W-1:0] pc);
    return m_hit(pc) ? m_tgt[idx_of(pc)] : '0;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: check last penalty, drive, check lookup, model the resolve
  task automatic step(logic [PC_W-1:0] lpc, logic rv, logic [PC_W-1:0] rpc,
                      logic rt, logic [PC_W-1:0] rtgt, string lreq);
    chk("R9", "pen_valid", 64'(pen_valid), 64'(pend));
    chk(p_req, "pen_outcome", 64'(pen_outcome), 64'(p_out));
    chk(p_req, "pen_cycles", 64'(pen_cycles), 64'(p_cyc));
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_target = rtgt;
    #1;
    chk(lreq, "lk_hit", 64'(lk_hit), 64'(m_hit(lpc)));
    chk(lreq, "lk_target", 64'(lk_target), 64'(m_target(lpc)));
    pend = rv; p_out = 2'd0; p_cyc = 2'd0; p_req = "R9";
    if (rv) begin
      int i = idx_of(rpc);
      if (rt) begin
        if (m_hit(rpc)) begin
          if (m_tgt[i] == rtgt) begin p_req = "R4"; end
          else begin p_req = "R5"; p_out = 2'd2; p_cyc = 2'd2; m_tgt[i] = rtgt; end
        end else begin
          p_req = m_vld[i] ? "R8" : "R3";
          p_out = 2'd1; p_cyc = 2'd1;
          m_vld[i] = 1'b1; m_tag[i] = tag_of(rpc); m_tgt[i] = rtgt;
        end
      end else begin
        if (m_hit(rpc)) begin p_req = "R6"; p_out = 2'd2; p_cyc = 2'd2; m_vld[i] = 1'b0; end
        else p_req = "R7";
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] a, b;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "lk_hit in reset", 64'(lk_hit), 64'd0);
    chk("R9", "rs_ready", 64'(rs_ready), 64'd1);
    chk("R9", "pen_valid in reset", 64'(pen_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      step(PC_W'(32'h0000_8000 + 4 * i), 1'b0, '0, 1'b0, '0, "R1");

    a = 32'h0000_1044;             // index 1
    b = 32'h0000_2044;             // index 1, other tag
    step(a, 1'b1, a, 1'b1, 32'h0000_5000, "R10");  // same-cycle lookup sees miss
    step(a, 1'b0, '0, 1'b0, '0, "R3");
    step(a, 1'b1, a, 1'b1, 32'h0000_5000, "R2");   // confirm
    step(a, 1'b1, a, 1'b1, 32'h0000_6000, "R10");  // retarget, lookup sees old
    step(a | 32'h3, 1'b0, '0, 1'b0, '0, "R11");
    step(a, 1'b1, a | 32'h2, 1'b0, '0, "R5");      // drop via offset-varied pc
    step(a, 1'b0, '0, 1'b0, '0, "R6");
    step(a, 1'b1, a, 1'b1, 32'h0000_7000, "R2");
    step(a, 1'b1, b, 1'b0, '0, "R2");              // not-taken miss, A stays
    step(a, 1'b1, b, 1'b1, 32'h0000_9000, "R7");   // alias replaces A
    step(a, 1'b0, '0, 1'b0, '0, "R8");
    step(b, 1'b0, '0, 1'b0, '0, "R8");

    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] lp, rp, tg;
      lp = {($urandom % 2 == 0) ? 26'h1 : 26'h2, 4'($urandom), 2'($urandom)};
      rp = {($urandom % 2 == 0) ? 26'h1 : 26'h2, 4'($urandom), 2'($urandom)};
      tg = {28'($urandom % 4), 4'h0};
      step(lp, 1'($urandom % 4 != 0), rp, 1'($urandom % 3 != 0), tg, "R2");
    end
    step('0, 1'b0, '0, 1'b0, '0, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule